// File: doc/BRIEF.md
# Priority Pin Crossbar Assigner

This block decides which on-chip digital peripheral signal drives each general-purpose port pin. Software supplies one enable bit per peripheral signal, an SPI wire-count select and a skip mask with one bit per pin. The block walks a fixed priority list of 22 signals. Each enabled signal receives the lowest-numbered pin that is free: not skipped and not already given to a signal of higher priority.

The asynchronous serial transmit and receive signals never take part in the search. Each one sits on a fixed pin of port 0 (bit 4 for transmit, bit 5 for receive). While enabled, those two pins are marked taken before the search starts. While disabled, the pins are open to other signals. The block drives three registered outputs: a selector code for each pin, which the pad multiplexers decode, and a pin index and a valid flag for each signal, which the peripherals use to find their pin.

Top module: `pxb_crossbar`

## Requirements
- R1: The priority list, with signal slot s (0-based) and its selector code s+1: 0 serial TX, 1 serial RX, 2 SDA, 3 SCL, 4 SCK, 5 MISO, 6 MOSI, 7 NSS, 8 comparator 0 synchronous, 9 comparator 0 asynchronous, 10 comparator 1 synchronous, 11 comparator 1 asynchronous, 12 system clock out, 13 to 18 capture/compare outputs 0 to 5, 19 external counter clock, 20 timer 0 input, 21 timer 1 input. Enable bit s of `sig_en` belongs to slot s. Slots are placed in ascending slot order.
- R2: When `sig_en[0]` is set, TX is placed on flat pin 4 with code 1. When `sig_en[1]` is set, RX is placed on flat pin 5 with code 2. This holds whatever the skip bits of those pins are.
- R3: When a serial signal is disabled, its fixed pin is open to searched signals.
- R4: Each enabled slot from 2 upward gets the lowest flat pin index (port*8+bit) that is neither skipped nor already assigned.
- R5: A set `skip_mask` bit at flat index port*8+bit keeps every searched signal off that pin, and the pin reads code 0.
- R6: Slot 7 (NSS) is placed only when `spi_four_wire` is 1. When it is 0, slot 7 gets no pin and does not consume one.
- R7: An enabled signal that finds no free pin has valid 0, pin index 0, and no pin carries its code.
- R8: Every pin not assigned to a signal carries code 0 (GPIO). Every nonzero pin code names a valid signal whose pin index is that pin.
- R9: Outputs follow the inputs with one clock of latency. A synchronous active-high reset sets every pin code, pin index and valid flag to 0.
- R10: A disabled signal has valid 0 and pin index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_en | input | 22 | Per-slot enable, bit s for slot s |
| spi_four_wire | input | 1 | 1 lets NSS take a pin |
| skip_mask | input | 8*NUM_PORTS | Per-pin skip, bit port*8+bit |
| pin_sel | output | 5*8*NUM_PORTS | Code of pin p at bits [5p+4:5p], 0 = GPIO |
| sig_pin | output | 22*IDX_W | Pin index of slot s at bits [IDX_W*s +: IDX_W] |
| sig_valid | output | 22 | Slot s holds a pin |

## Verification
Four kinds of input pattern are used. All searched signals with no skips gives a dense, gap-free packing and shows that the order is correct. Skip patterns, including the two low pins of port 1, show that skipped pins are passed over without disturbing the order. With the serial pair on and off, and with its fixed pins skipped, the run separates fixed placement from the search. Nearly every pin skipped exhausts the pool and shows which low-priority signals lose out. Several hundred random enable, skip and wire-mode patterns are then checked against a behavioural model on every clock.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
    localparam int PINS_PER_PORT = 8;
    localparam int NUM_SIGNALS   = 22;
    localparam int SEL_W         = 5;
    localparam int TX_SLOT       = 0;
    localparam int RX_SLOT       = 1;
    localparam int NSS_SLOT      = 7;
    localparam int TX_PIN        = 4;
    localparam int RX_PIN        = 5;
    localparam int FIRST_SEARCH  = 2;

    typedef enum logic [SEL_W-1:0] {
        FN_GPIO   = 5'd0,
        FN_UTX    = 5'd1,
        FN_URX    = 5'd2,
        FN_SDA    = 5'd3,
        FN_SCL    = 5'd4,
        FN_SCK    = 5'd5,
        FN_MISO   = 5'd6,
        FN_MOSI   = 5'd7,
        FN_NSS    = 5'd8,
        FN_CMP0S  = 5'd9,
        FN_CMP0A  = 5'd10,
        FN_CMP1S  = 5'd11,
        FN_CMP1A  = 5'd12,
        FN_SYSCLK = 5'd13,
        FN_CC0    = 5'd14,
        FN_CC1    = 5'd15,
        FN_CC2    = 5'd16,
        FN_CC3    = 5'd17,
        FN_CC4    = 5'd18,
        FN_CC5    = 5'd19,
        FN_ECLK   = 5'd20,
        FN_TIM0   = 5'd21,
        FN_TIM1   = 5'd22
    } pin_func_e;

    function automatic logic [SEL_W-1:0] slot_code(input int slot);
        return SEL_W'(slot + 1);
    endfunction
endpackage

// File: rtl/pxb_first_free.sv
module pxb_first_free #(
    parameter int N     = 32,
    parameter int IDX_W = 5
) (
    input  logic [N-1:0]     busy,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pxb_alloc_stage.sv
module pxb_alloc_stage #(
    parameter int N     = 32,
    parameter int IDX_W = 5
) (
    input  logic             want,
    input  logic [N-1:0]     busy_in,
    output logic [N-1:0]     busy_out,
    output logic             granted,
    output logic [IDX_W-1:0] pin
);
    logic             any_free;
    logic [IDX_W-1:0] cand;

    pxb_first_free #(.N(N), .IDX_W(IDX_W)) ff_i (
        .busy  (busy_in),
        .found (any_free),
        .idx   (cand)
    );

    always_comb begin
        granted  = want && any_free;
        pin      = granted ? cand : '0;
        busy_out = busy_in;
        if (granted) busy_out[cand] = 1'b1;
    end
endmodule

// File: rtl/pxb_fixed_claim.sv
module pxb_fixed_claim #(
    parameter int N = 32
) (
    input  logic         tx_on,
    input  logic         rx_on,
    input  logic [N-1:0] skip,
    output logic [N-1:0] busy_init
);
    import pxb_pkg::*;
    always_comb begin
        busy_init = skip;
        if (tx_on) busy_init[TX_PIN] = 1'b1;
        if (rx_on) busy_init[RX_PIN] = 1'b1;
    end
endmodule

// File: rtl/pxb_crossbar.sv
module pxb_crossbar #(
    parameter int NUM_PORTS = 4,
    localparam int NUM_PINS = NUM_PORTS * pxb_pkg::PINS_PER_PORT,
    localparam int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
    localparam int NSIG     = pxb_pkg::NUM_SIGNALS,
    localparam int SEL_W    = pxb_pkg::SEL_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NSIG-1:0]           sig_en,
    input  logic                      spi_four_wire,
    input  logic [NUM_PINS-1:0]       skip_mask,
    output logic [NUM_PINS*SEL_W-1:0] pin_sel,
    output logic [NSIG*IDX_W-1:0]     sig_pin,
    output logic [NSIG-1:0]           sig_valid
);
    import pxb_pkg::*;

    typedef struct packed {
        logic [NUM_PINS-1:0][SEL_W-1:0] sel;
        logic [NSIG-1:0][IDX_W-1:0]     pin;
        logic [NSIG-1:0]                valid;
    } route_t;

    route_t route_d, route_q;

    logic [NUM_PINS-1:0]        busy_chain [FIRST_SEARCH:NSIG];
    logic [NSIG-1:0]            stage_ok;
    logic [NSIG-1:0][IDX_W-1:0] stage_pin;

    pxb_fixed_claim #(.N(NUM_PINS)) claim_i (
        .tx_on     (sig_en[TX_SLOT]),
        .rx_on     (sig_en[RX_SLOT]),
        .skip      (skip_mask),
        .busy_init (busy_chain[FIRST_SEARCH])
    );

    for (genvar s = 0; s < NSIG; s++) begin : g_slot
        if (s < FIRST_SEARCH) begin : g_fixed
            assign stage_ok[s]  = 1'b0;
            assign stage_pin[s] = '0;
        end else begin : g_search
            logic want;
            if (s == NSS_SLOT) begin : g_nss
                assign want = sig_en[s] && spi_four_wire;
            end else begin : g_plain
                assign want = sig_en[s];
            end
            pxb_alloc_stage #(.N(NUM_PINS), .IDX_W(IDX_W)) stage_i (
                .want     (want),
                .busy_in  (busy_chain[s]),
                .busy_out (busy_chain[s+1]),
                .granted  (stage_ok[s]),
                .pin      (stage_pin[s])
            );
        end
    end

    always_comb begin
        route_d = '0;
        if (sig_en[TX_SLOT]) begin
            route_d.valid[TX_SLOT] = 1'b1;
            route_d.pin[TX_SLOT]   = IDX_W'(TX_PIN);
            route_d.sel[TX_PIN]    = FN_UTX;
        end
        if (sig_en[RX_SLOT]) begin
            route_d.valid[RX_SLOT] = 1'b1;
            route_d.pin[RX_SLOT]   = IDX_W'(RX_PIN);
            route_d.sel[RX_PIN]    = FN_URX;
        end
        for (int s = FIRST_SEARCH; s < NSIG; s++) begin
            if (stage_ok[s]) begin
                route_d.valid[s]            = 1'b1;
                route_d.pin[s]              = stage_pin[s];
                route_d.sel[stage_pin[s]]   = slot_code(s);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) route_q <= '0;
        else     route_q <= route_d;
    end

    assign pin_sel   = route_q.sel;
    assign sig_pin   = route_q.pin;
    assign sig_valid = route_q.valid;
endmodule

// File: rtl/pxb_crossbar_chk.sv
module pxb_crossbar_chk #(
    parameter int NUM_PORTS = 4,
    localparam int NUM_PINS = NUM_PORTS * pxb_pkg::PINS_PER_PORT,
    localparam int IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
    localparam int NSIG     = pxb_pkg::NUM_SIGNALS,
    localparam int SEL_W    = pxb_pkg::SEL_W
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NSIG-1:0]           sig_en,
    input logic                      spi_four_wire,
    input logic [NUM_PINS-1:0]       skip_mask,
    input logic [NUM_PINS*SEL_W-1:0] pin_sel,
    input logic [NSIG*IDX_W-1:0]     sig_pin,
    input logic [NSIG-1:0]           sig_valid
);
    import pxb_pkg::*;

    p_reset_gpio_r9: assert property (@(posedge clk) rst |=> (pin_sel == '0 && sig_valid == '0));

    p_tx_fixed_r2: assert property (@(posedge clk) disable iff (rst)
        sig_en[TX_SLOT] |=> (pin_sel[TX_PIN*SEL_W +: SEL_W] == SEL_W'(1) && sig_valid[TX_SLOT]));

    p_rx_fixed_r2: assert property (@(posedge clk) disable iff (rst)
        sig_en[RX_SLOT] |=> (pin_sel[RX_PIN*SEL_W +: SEL_W] == SEL_W'(2) && sig_valid[RX_SLOT]));

    p_nss_three_wire_r6: assert property (@(posedge clk) disable iff (rst)
        !spi_four_wire |=> !sig_valid[NSS_SLOT]);

    for (genvar s = 0; s < NSIG; s++) begin : g_sig
        p_disabled_r10: assert property (@(posedge clk) disable iff (rst)
            !sig_en[s] |=> !sig_valid[s]);
        p_no_pin_idx_r7: assert property (@(posedge clk) disable iff (rst)
            !sig_valid[s] |-> sig_pin[s*IDX_W +: IDX_W] == '0);
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam bit FIXED = (p == TX_PIN) || (p == RX_PIN);
        logic [SEL_W-1:0] code;
        assign code = pin_sel[p*SEL_W +: SEL_W];

        p_owner_r8: assert property (@(posedge clk) disable iff (rst)
            (code != '0) |-> (int'(code) <= NSIG && sig_valid[int'(code)-1]
                && int'(sig_pin[(int'(code)-1)*IDX_W +: IDX_W]) == p));

        if (!FIXED) begin : g_skip
            p_skip_r5: assert property (@(posedge clk) disable iff (rst)
                skip_mask[p] |=> (code == '0));
        end else begin : g_skip_fixed
            p_skip_fixed_r5: assert property (@(posedge clk) disable iff (rst)
                (skip_mask[p] && !sig_en[p - TX_PIN]) |=> (code == '0));
        end
    end
endmodule

bind pxb_crossbar pxb_crossbar_chk #(.NUM_PORTS(NUM_PORTS)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .sig_en        (sig_en),
    .spi_four_wire (spi_four_wire),
    .skip_mask     (skip_mask),
    .pin_sel       (pin_sel),
    .sig_pin       (sig_pin),
    .sig_valid     (sig_valid)
);

// File: tb/pxb_crossbar_tb.sv
module pxb_crossbar_tb_top;
    localparam int NP   = 32;
    localparam int NS   = 22;
    localparam int IW   = 5;
    localparam int SW   = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NS-1:0]     sig_en = '0;
    logic              spi_four_wire = 1'b0;
    logic [NP-1:0]     skip_mask = '0;
    logic [NP*SW-1:0]  pin_sel;
    logic [NS*IW-1:0]  sig_pin;
    logic [NS-1:0]     sig_valid;

    int checks = 0;
    int fails  = 0;

    logic [NP*SW-1:0] exp_sel;
    logic [NS*IW-1:0] exp_pin;
    logic [NS-1:0]    exp_val;

    always #4 clk = ~clk;

    pxb_crossbar #(.NUM_PORTS(4)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .sig_en        (sig_en),
        .spi_four_wire (spi_four_wire),
        .skip_mask     (skip_mask),
        .pin_sel       (pin_sel),
        .sig_pin       (sig_pin),
        .sig_valid     (sig_valid)
    );

    task automatic model(input logic r);
        bit taken [NP];
        exp_sel = '0;
        exp_pin = '0;
        exp_val = '0;
        if (r) return;
        for (int p = 0; p < NP; p++) taken[p] = skip_mask[p];
        if (sig_en[0]) taken[4] = 1;
        if (sig_en[1]) taken[5] = 1;
        for (int s = 0; s < NS; s++) begin
            int chosen = -1;
            if (!sig_en[s]) continue;
            if (s == 7 && !spi_four_wire) continue;
            if (s == 0) chosen = 4;
            else if (s == 1) chosen = 5;
            else begin
                for (int p = 0; p < NP; p++) begin
                    if (!taken[p]) begin
                        chosen = p;
                        break;
                    end
                end
                if (chosen >= 0) taken[chosen] = 1;
            end
            if (chosen >= 0) begin
                exp_val[s] = 1'b1;
                exp_pin[s*IW +: IW] = IW'(chosen);
                exp_sel[chosen*SW +: SW] = SW'(s + 1);
            end
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (pin_sel !== exp_sel) begin
            fails++;
            $display("FAIL %s pin_sel actual=%h expected=%h", tag, pin_sel, exp_sel);
        end
        checks++;
        if (sig_pin !== exp_pin) begin
            fails++;
            $display("FAIL %s sig_pin actual=%h expected=%h", tag, sig_pin, exp_pin);
        end
        checks++;
        if (sig_valid !== exp_val) begin
            fails++;
            $display("FAIL %s sig_valid actual=%h expected=%h", tag, sig_valid, exp_val);
        end
    endtask

    // Drive at a falling edge, let one rising edge register, compare at the next falling edge.
    task automatic step(input logic r, input logic [NS-1:0] en, input logic [NP-1:0] sk,
                        input logic fw, input string tag);
        rst = r;
        sig_en = en;
        skip_mask = sk;
        spi_four_wire = fw;
        model(r);
        @(negedge clk);
        compare(tag);
    endtask

    localparam logic [NS-1:0] SEARCHED = 22'h3FFFFC;
    localparam logic [NS-1:0] ALL_ON   = 22'h3FFFFF;

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        @(negedge clk);
        // R9: reset state
        step(1'b1, ALL_ON, '0, 1'b1, "R9 reset");
        step(1'b1, '0, '0, 1'b0, "R9 reset");
        // R4 / R1: all searched signals, nothing skipped, dense packing from pin 0
        step(1'b0, SEARCHED, '0, 1'b1, "R4 dense");
        // R3: serial off so pins 4 and 5 go to searched signals
        step(1'b0, SEARCHED & ~22'h80, '0, 1'b0, "R3 fixed pins free");
        // R2: serial on, its fixed pins skipped too
        step(1'b0, ALL_ON, 32'h0000_0030, 1'b1, "R2 fixed over skip");
        step(1'b0, 22'h000003, '0, 1'b0, "R2 serial only");
        step(1'b0, 22'h000001, '0, 1'b0, "R2 tx only");
        // R5: port 1 bits 0 and 1 skipped
        step(1'b0, ALL_ON, 32'h0000_0300, 1'b1, "R5 port1 low skipped");
        step(1'b0, SEARCHED, 32'hAAAA_AAAA, 1'b1, "R5 alternate skip");
        // R6: NSS gated by wire mode
        step(1'b0, 22'h0000F0, '0, 1'b0, "R6 three wire");
        step(1'b0, 22'h0000F0, '0, 1'b1, "R6 four wire");
        // R7: pool exhausted
        step(1'b0, ALL_ON, 32'hFFFF_FFF8, 1'b1, "R7 exhausted");
        step(1'b0, SEARCHED, 32'hFFFF_FFFF, 1'b1, "R7 all skipped");
        // R10 / R8: sparse enables
        step(1'b0, 22'h200005, 32'h0000_0001, 1'b0, "R10 sparse");
        step(1'b0, '0, 32'h1234_5678, 1'b1, "R8 none enabled");
        // R9: reset mid-run, then recovery
        step(1'b1, ALL_ON, '0, 1'b1, "R9 reset again");
        step(1'b0, ALL_ON, '0, 1'b1, "R9 recovery");
        // R1: random patterns
        for (int i = 0; i < 400; i++) begin
            logic [NP-1:0] sk;
            sk = $urandom() & $urandom();
            step(1'b0, NS'($urandom()), sk, 1'($urandom()), "R1 random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule